// File: doc/BRIEF.md
# Combined Ready/Data Serial Target

This block is the device side of a two-wire readout link. The host drives one clock line and the device drives one return line. When idle, the return line sits high. It drops low to announce a fresh conversion result. After that, the same line carries the result bits, one per host clock rising edge.

There are no command bits. The host chooses what happens next by the number of clock pulses it sends and by how long it holds the clock high:
- An extra pulse after the frame releases the ready line.
- One more pulse after that requests a self-calibration.
- A long high phase at any time after a result has been announced puts the device to sleep.
- Bringing the clock low again wakes the device, and also requests a calibration if the pulse held high was the calibration pulse.

The host clock is asynchronous. The block synchronizes it with two flops and detects its edges in the system clock domain. The conversion engine supplies each new result with a one-cycle strobe. The block returns single-cycle pulses that ask for calibration, announce sleep entry and announce wake-up.

Top module: `rdy_dout_target`

## Requirements
- R1: After reset, `rdy_dout` is high and `cal_req`, `sleep_enter` and `wake` are low.
- R2: A `result_valid` strobe while awake drives `rdy_dout` low one cycle later.
- R3: Host clock rising edges 1 to 16 after a result present the result bits on `rdy_dout`, most significant bit first, with bit 15 on edge 1 and bit 0 on edge 16. The result is in two's complement form.
- R4: Rising edges 17 to 24 of the frame present 0 on `rdy_dout`.
- R5: The 25th rising edge drives `rdy_dout` high.
- R6: If no further edge arrives, `rdy_dout` keeps the value of the last bit presented.
- R7: The falling edge of the 26th pulse raises `cal_req` for exactly one cycle. This pulse never coincides with `sleep_enter`.
- R8: Once a result has been announced, a host clock high phase lasting at least `SLEEP_HOLD` system cycles makes the block sleep. It raises `sleep_enter` for one cycle and drives `rdy_dout` high. High phases of a few cycles act as ordinary clock pulses and never cause sleep.
- R9: While the block is asleep, `result_valid` is ignored and `rdy_dout` stays high. A host clock fall wakes the block with a one-cycle `wake` pulse and no `cal_req`.
- R10: If the host held the clock high for sleep on the 26th pulse, the wake-up also raises `cal_req` in the same cycle as `wake`.
- R11: A new result replaces an unread or partly read one. The next frame then starts again at edge 1 with the new bits.
- R12: If no result has been announced since reset or since the last sleep or calibration, a long high phase does not cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| result_valid | input | 1 | One-cycle strobe: new conversion result |
| result_data | input | DATA_W | Conversion result, two's complement |
| rdy_dout | output | 1 | Ready flag (low) and serial data |
| cal_req | output | 1 | One-cycle self-calibration request |
| sleep_enter | output | 1 | One-cycle sleep entry pulse |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
A change on the host clock passes two synchronizer flops and the edge detector. The registered output therefore moves on the third system clock after the host clock is driven, and the command pulses follow in the same cycle. The bench holds each host clock phase for four system cycles and samples on the falling system clock edge after that phase. A result strobe shows on `rdy_dout` one cycle later, and the bench samples it on the next falling edge. Sleep entry happens roughly `SLEEP_HOLD` plus three cycles into a high phase, so the bench holds the clock high well beyond that. It counts pulses continuously, which makes each pulse check independent of the exact cycle the pulse lands in.

// File: rtl/rdy_dout_target.sv
module rdy_dout_target #(
  parameter int DATA_W     = 16,
  parameter int FRAME_LEN  = 24,
  parameter int SLEEP_HOLD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              result_valid,
  input  logic [DATA_W-1:0] result_data,
  output logic              rdy_dout,
  output logic              cal_req,
  output logic              sleep_enter,
  output logic              wake
);
  localparam int CNT_W  = $clog2(FRAME_LEN + 3);
  localparam int HOLD_W = $clog2(SLEEP_HOLD + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0]  CAL_EDGE = CNT_W'(FRAME_LEN + 2);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(SLEEP_HOLD - 1);

  logic [2:0]        sync_q;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hcnt;
  logic              asleep, armed, cal_wake, dout_q;

  wire sclk_hi   = sync_q[1];
  wire rise      = sync_q[1] & ~sync_q[2];
  wire fall      = ~sync_q[1] & sync_q[2];
  wire sleep_hit = sclk_hi && (hcnt == HOLD_MAX) && armed;

  assign rdy_dout = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hcnt   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_in};
      if (!sclk_hi)              hcnt <= '0;
      else if (hcnt != HOLD_MAX) hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      cnt         <= '0;
      asleep      <= 1'b0;
      armed       <= 1'b0;
      cal_wake    <= 1'b0;
      dout_q      <= 1'b1;
      cal_req     <= 1'b0;
      sleep_enter <= 1'b0;
      wake        <= 1'b0;
    end else begin
      cal_req     <= 1'b0;
      sleep_enter <= 1'b0;
      wake        <= 1'b0;
      if (asleep) begin
        if (fall) begin
          asleep   <= 1'b0;
          wake     <= 1'b1;
          cal_req  <= cal_wake;
          cal_wake <= 1'b0;
          cnt      <= '0;
        end
      end else if (result_valid) begin
        shreg  <= result_data;
        dout_q <= 1'b0;
        cnt    <= '0;
        armed  <= 1'b1;
      end else if (sleep_hit) begin
        asleep      <= 1'b1;
        sleep_enter <= 1'b1;
        dout_q      <= 1'b1;
        armed       <= 1'b0;
        cal_wake    <= (cnt == CAL_EDGE);
        cnt         <= '0;
      end else if (rise && armed && cnt != CAL_EDGE) begin
        cnt <= cnt + 1'b1;
        if (cnt < LAST_BIT) begin
          dout_q <= shreg[DATA_W-1];
          shreg  <= {shreg[DATA_W-2:0], 1'b0};
        end else if (cnt == LAST_BIT) begin
          dout_q <= 1'b1;
        end
      end else if (fall && cnt == CAL_EDGE) begin
        cal_req <= 1'b1;
        cnt     <= '0;
        armed   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdy_dout_target_chk.sv
module rdy_dout_target_chk (
  input logic clk,
  input logic rst_n,
  input logic result_valid,
  input logic asleep,
  input logic sclk_hi,
  input logic rdy_dout,
  input logic cal_req,
  input logic sleep_enter,
  input logic wake
);
  AST_READY_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !asleep) |=> !rdy_dout); // R2
  AST_SLEEP_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |-> rdy_dout); // R8
  AST_SLEEP_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |-> $past(sclk_hi)); // R8
  AST_ASLEEP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> rdy_dout); // R9
  AST_WAKE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !$past(sclk_hi)); // R9
  AST_CAL_NOT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_enter && (cal_req || wake))); // R7
endmodule

bind rdy_dout_target rdy_dout_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .asleep(asleep),
  .sclk_hi(sync_q[1]), .rdy_dout(rdy_dout), .cal_req(cal_req),
  .sleep_enter(sleep_enter), .wake(wake)
);

// File: tb/tb_rdy_dout_target.sv
module tb_rdy_dout_target;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0, sclk_in = 1'b0, result_valid = 1'b0;
  logic [DW-1:0] result_data = '0;
  logic rdy_dout, cal_req, sleep_enter, wake;
  int total = 0, bad = 0, n_cal = 0, n_sleep = 0, n_wake = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdy_dout_target dut (.clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
    .result_valid(result_valid), .result_data(result_data), .rdy_dout(rdy_dout),
    .cal_req(cal_req), .sleep_enter(sleep_enter), .wake(wake));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cal_req) n_cal <= n_cal + 1;
    if (sleep_enter) n_sleep <= n_sleep + 1;
    if (wake) n_wake <= n_wake + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad = bad + 1;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic post(input logic [DW-1:0] d);
    @(negedge clk); result_data = d; result_valid = 1'b1;
    @(negedge clk); result_valid = 1'b0;
  endtask

  task automatic rise_edge();
    @(negedge clk); sclk_in = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fall_edge();
    @(negedge clk); sclk_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_bit(input logic [DW-1:0] d, input int k);
    return (k <= DW) ? int'(d[DW-k]) : 0;
  endfunction

  task automatic frame(input logic [DW-1:0] d, input int edges);
    for (int k = 1; k <= edges; k++) begin
      rise_edge();
      if (k <= DW) chk("R3", rdy_dout, exp_bit(d, k));
      else if (k <= 24) chk("R4", rdy_dout, 0);
      else if (k == 25) chk("R5", rdy_dout, 1);
      fall_edge();
    end
  endtask

  initial begin
    int c0, s0, w0;
    logic [DW-1:0] pats [6] = '{16'h8000, 16'h7FFF, 16'hA5C3, 16'h0001, 16'hFFFF, 16'h0000};
    repeat (3) @(negedge clk);
    chk("R1", rdy_dout, 1);
    chk("R1", cal_req | sleep_enter | wake, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12: no result yet, long high is ignored
    @(negedge clk); sclk_in = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R12", n_sleep, 0);
    fall_edge();

    foreach (pats[i]) begin
      post(pats[i]);
      chk("R2", rdy_dout, 0);
      frame(pats[i], 25);
    end
    for (int b = 0; b < DW; b++) begin
      post(DW'(1) << b);
      frame(DW'(1) << b, 25);
    end
    chk("R8", n_sleep, 0);
    chk("R7", n_cal, 0);

    // R6: stop after 16 edges
    post(16'h1235);
    frame(16'h1235, 16);
    repeat (20) @(negedge clk);
    chk("R6", rdy_dout, 1);
    post(16'h1234);
    frame(16'h1234, 16);
    repeat (20) @(negedge clk);
    chk("R6", rdy_dout, 0);

    // R11: overwrite mid-read
    post(16'hF0F0);
    frame(16'hF0F0, 5);
    post(16'h0F0F);
    chk("R11", rdy_dout, 0);
    frame(16'h0F0F, 25);

    // R7: 26th pulse requests calibration on its fall
    post(16'h3C3C);
    frame(16'h3C3C, 25);
    c0 = n_cal;
    rise_edge();
    chk("R7", n_cal - c0, 0);
    fall_edge();
    chk("R7", n_cal - c0, 1);

    // R8/R9: sleep part-way through a read
    post(16'hBEEF);
    frame(16'hBEEF, 3);
    s0 = n_sleep; w0 = n_wake; c0 = n_cal;
    @(negedge clk); sclk_in = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R8", n_sleep - s0, 1);
    chk("R8", rdy_dout, 1);
    post(16'h0000);
    chk("R9", rdy_dout, 1);
    fall_edge();
    chk("R9", n_wake - w0, 1);
    chk("R9", n_cal - c0, 0);
    chk("R9", rdy_dout, 1);

    // R10: 26th pulse held high, calibration at wake
    post(16'h5A5A);
    frame(16'h5A5A, 25);
    s0 = n_sleep; w0 = n_wake; c0 = n_cal;
    @(negedge clk); sclk_in = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R10", n_sleep - s0, 1);
    chk("R10", n_cal - c0, 0);
    fall_edge();
    chk("R10", n_wake - w0, 1);
    chk("R10", n_cal - c0, 1);

    // after wake a fresh result reads normally
    post(16'hC001);
    frame(16'hC001, 25);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule